// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the transmit half of a DMA engine. Software places two-word descriptors in memory: a word that holds the word address of a buffer, then a control word. It hands each descriptor to hardware by leaving its ownership flag clear. After a start pulse the engine walks the ring. For each descriptor it fetches the buffer bytes, sends them out on a byte stream with a valid/ready handshake, and then writes the control word back with the ownership flag set. A descriptor whose ownership flag is already set ends the walk. Reaching such a descriptor in the middle of a frame, or getting an underrun report from the downstream MAC, is recorded in the descriptor and in a sticky error flag.

Memory is reached through a simple word port with a read latency of one cycle. Bytes are packed four to a word, least significant byte first. A halt pulse lets the frame in progress run to its end, and the engine stops at the next frame boundary.

Top module: `tx_desc_ring_reader`

## Requirements
- R1: While reset is asserted and in the cycle after it, busy_o, err_o and tx_valid_o are low. The read pointer returns to the first descriptor at ring_base_i.
- R2: Descriptor n sits at ring_base_i+2n. Word 0 holds the buffer's word address. Word 1 is the control word: bits 10:0 are the length in bytes, bit 15 marks the last buffer of a frame, bit 16 asks for no CRC, bit 30 marks the final ring entry, and bit 31 is the used flag. The memory port never reads and writes in the same cycle.
- R3: A descriptor whose used flag is clear produces exactly `length` bytes on tx_data_o, in order, taking byte k from bits 8*(k mod 4)+7 : 8*(k mod 4) of buffer word k/4. Data is held stable while tx_ready_i is low.
- R4: tx_last_o is high only with the final byte of a descriptor whose bit 15 is set. tx_nocrc_o carries bit 16 of the descriptor being sent.
- R5: Once a buffer has been consumed, its control word is written back unchanged except that bit 31 is set.
- R6: If the engine meets a descriptor with bit 31 set between frames, it goes idle and drops busy_o without writing anything. The next start resumes at that same descriptor.
- R7: The descriptor after one with bit 30 set is the one at ring_base_i.
- R8: If the engine meets a descriptor with bit 31 set before the end of the current frame, it writes that control word back with bit 27 also set, sets err_o, and goes idle. err_o stays set until reset.
- R9: If underrun_i is asserted while bytes are being sent, the engine stops sending. It writes the control word back with bits 31 and 28 set, sets err_o, and goes idle. The next start continues with the following descriptor.
- R10: A halt pulse stops the engine at the next frame boundary. busy_o stays high until the current frame has finished, and no descriptor after that frame is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse: begin walking the ring |
| halt_i | input | 1 | Pulse: stop at the next frame boundary |
| ring_base_i | input | AW | Word address of the first descriptor |
| busy_o | output | 1 | Engine is active |
| err_o | output | 1 | Sticky error: exhausted or underrun |
| mem_rd_o | output | 1 | Memory read request, data valid next cycle |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| tx_valid_o | output | 1 | Byte stream valid |
| tx_ready_i | input | 1 | Byte stream ready |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_nocrc_o | output | 1 | Frame must go out without CRC |
| underrun_i | input | 1 | Downstream starved while sending |

## Verification
The bench sends a frame that spans two descriptors, with odd lengths, under a ready pattern that stalls. A wrong byte lane or word step would show up as bytes out of order, and a misplaced last marker would mark the end of the first buffer. It checks the return to the base after the wrap flag, and that the engine stops on a used descriptor between frames. An engine that ignored the used flag would stream stale buffers, and one that lost the wrap would read past the ring. Used-descriptor-in-mid-frame and underrun are forced, and the bench looks for bits 27 and 28 in memory, the sticky error, and that the next start resumes at the correct place. A halt issued part way through a two-buffer frame has to let that frame finish and leave the next descriptor untouched.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int CW_LEN_W   = 11;
    localparam int CW_LAST    = 15;
    localparam int CW_NOCRC   = 16;
    localparam int CW_EXHAUST = 27;
    localparam int CW_UNDER   = 28;
    localparam int CW_WRAP    = 30;
    localparam int CW_USED    = 31;

    typedef struct packed {
        logic                used;
        logic                wrap;
        logic                nocrc;
        logic                last;
        logic [CW_LEN_W-1:0] len;
    } tdr_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_WT_CTRL,
        ST_WT_ADDR,
        ST_RD_DATA,
        ST_WT_DATA,
        ST_STREAM,
        ST_WB
    } tdr_state_t;

    function automatic tdr_ctrl_t tdr_decode(input logic [31:0] w);
        tdr_ctrl_t c;
        c.used  = w[CW_USED];
        c.wrap  = w[CW_WRAP];
        c.nocrc = w[CW_NOCRC];
        c.last  = w[CW_LAST];
        c.len   = w[CW_LEN_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance_i,
    input  logic          wrap_i,
    output logic [AW-1:0] off_o
);
    localparam logic [AW-1:0] STEP = AW'(2);

    always_ff @(posedge clk) begin
        if (rst)
            off_o <= '0;
        else if (advance_i)
            off_o <= wrap_i ? '0 : off_o + STEP;
    end
endmodule

// File: rtl/tdr_byte_sel.sv
module tdr_byte_sel #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0]       word_i,
    input  logic [$clog2(BYTES)-1:0] sel_i,
    output logic [7:0]               byte_o
);
    logic [7:0] lane [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g] = word_i[8*g +: 8];
    end

    assign byte_o = lane[sel_i];
endmodule

// File: rtl/tx_desc_ring_reader.sv
module tx_desc_ring_reader
    import tdr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          halt_i,
    input  logic [AW-1:0] ring_base_i,
    output logic          busy_o,
    output logic          err_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    output logic          tx_valid_o,
    input  logic          tx_ready_i,
    output logic [7:0]    tx_data_o,
    output logic          tx_last_o,
    output logic          tx_nocrc_o,
    input  logic          underrun_i
);
    localparam int BYTES = 4;
    localparam int SEL_W = $clog2(BYTES);
    localparam int CNT_W = CW_LEN_W;

    tdr_state_t       state;
    logic [31:0]      ctrl_w;
    tdr_ctrl_t        cur;
    tdr_ctrl_t        fresh;
    logic [AW-1:0]    buf_addr;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      word_q;
    logic [31:0]      wb_val;
    logic             wb_adv;
    logic             wb_inframe;
    logic             wb_stop;
    logic             in_frame;
    logic             halt_pend;
    logic             err_q;
    logic [AW-1:0]    off;
    logic [AW-1:0]    desc_a;
    logic             final_byte;
    logic             streaming;

    assign cur        = tdr_decode(ctrl_w);
    assign fresh      = tdr_decode(mem_rdata_i);
    assign desc_a     = ring_base_i + off;
    assign final_byte = ({1'b0, cnt} + 12'd1) == {1'b0, cur.len};
    assign streaming  = (state == ST_STREAM) && !underrun_i;

    if (AW < 32) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^mem_rdata_i[31:AW];
    end

    tdr_ring_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .advance_i (state == ST_WB && wb_adv),
        .wrap_i    (cur.wrap),
        .off_o     (off)
    );

    tdr_byte_sel #(.BYTES(BYTES)) u_sel (
        .word_i (word_q),
        .sel_i  (cnt[SEL_W-1:0]),
        .byte_o (tx_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ctrl_w     <= '0;
            buf_addr   <= '0;
            cnt        <= '0;
            word_q     <= '0;
            wb_val     <= '0;
            wb_adv     <= 1'b0;
            wb_inframe <= 1'b0;
            wb_stop    <= 1'b0;
            in_frame   <= 1'b0;
            halt_pend  <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (halt_i && state != ST_IDLE)
                halt_pend <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        halt_pend <= 1'b0;
                        state     <= ST_RD_CTRL;
                    end
                end
                ST_RD_CTRL: state <= ST_WT_CTRL;
                ST_WT_CTRL: begin
                    ctrl_w <= mem_rdata_i;
                    if (fresh.used) begin
                        if (in_frame) begin
                            wb_val                 <= mem_rdata_i;
                            wb_val[CW_EXHAUST]     <= 1'b1;
                            wb_adv                 <= 1'b0;
                            wb_inframe             <= 1'b0;
                            wb_stop                <= 1'b1;
                            err_q                  <= 1'b1;
                            state                  <= ST_WB;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        state <= ST_WT_ADDR;
                    end
                end
                ST_WT_ADDR: begin
                    buf_addr   <= mem_rdata_i[AW-1:0];
                    cnt        <= '0;
                    wb_val     <= ctrl_w | (32'd1 << CW_USED);
                    wb_adv     <= 1'b1;
                    wb_inframe <= !cur.last;
                    wb_stop    <= 1'b0;
                    state      <= (cur.len == '0) ? ST_WB : ST_RD_DATA;
                end
                ST_RD_DATA: state <= ST_WT_DATA;
                ST_WT_DATA: begin
                    word_q <= mem_rdata_i;
                    state  <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (underrun_i) begin
                        wb_val             <= ctrl_w | (32'd1 << CW_USED);
                        wb_val[CW_UNDER]   <= 1'b1;
                        wb_inframe         <= 1'b0;
                        wb_stop            <= 1'b1;
                        err_q              <= 1'b1;
                        state              <= ST_WB;
                    end else if (tx_ready_i) begin
                        cnt <= cnt + 1'b1;
                        if (final_byte)
                            state <= ST_WB;
                        else if (cnt[SEL_W-1:0] == SEL_W'(BYTES-1))
                            state <= ST_RD_DATA;
                    end
                end
                ST_WB: begin
                    in_frame <= wb_inframe;
                    if (!wb_inframe && (wb_stop || halt_pend))
                        state <= ST_IDLE;
                    else
                        state <= ST_RD_CTRL;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd_o   = (state == ST_RD_CTRL) || (state == ST_RD_DATA) ||
                     (state == ST_WT_CTRL && !fresh.used);
        mem_wr_o   = (state == ST_WB);
        mem_wdata_o = wb_val;
        unique case (state)
            ST_RD_CTRL, ST_WB: mem_addr_o = desc_a + AW'(1);
            ST_RD_DATA:        mem_addr_o = buf_addr + AW'(cnt[CNT_W-1:SEL_W]);
            default:           mem_addr_o = desc_a;
        endcase
    end

    assign busy_o     = (state != ST_IDLE);
    assign err_o      = err_q;
    assign tx_valid_o = streaming;
    assign tx_last_o  = streaming && final_byte && cur.last;
    assign tx_nocrc_o = streaming && cur.nocrc;
endmodule

// File: rtl/tdr_checks.sv
module tdr_checks (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        err_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [31:0] mem_wdata_o,
    input logic        tx_valid_o,
    input logic        tx_ready_i,
    input logic [7:0]  tx_data_o,
    input logic        tx_last_o,
    input logic        underrun_i
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy_o && !err_o && !tx_valid_o)); // R1

    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o)); // R2

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i) |=>
        ((tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)) || underrun_i)); // R3

    AST_WB_OWNED: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> mem_wdata_o[31]); // R5

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!tx_valid_o && !mem_rd_o && !mem_wr_o)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o); // R8
endmodule

bind tx_desc_ring_reader tdr_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_data_o   (tx_data_o),
    .tx_last_o   (tx_last_o),
    .underrun_i  (underrun_i)
);

// File: tb/tx_desc_ring_reader_tb_top.sv
module tx_desc_ring_reader_tb_top;
    localparam int AW   = 16;
    localparam int BASE = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          halt_i = 1'b0;
    logic [AW-1:0] ring_base_i = AW'(BASE);
    logic          busy_o, err_o, mem_rd_o, mem_wr_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0]   mem_wdata_o;
    logic [31:0]   mem_rdata_i = '0;
    logic          tx_valid_o, tx_last_o, tx_nocrc_o;
    logic          tx_ready_i = 1'b0;
    logic [7:0]    tx_data_o;
    logic          underrun_i = 1'b0;

    int checks = 0;
    int failures = 0;
    int rdy_mode = 0;
    int rdy_cnt = 0;
    logic [9:0] exp_q [$];

    logic [31:0] mem [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_a = '0;
    logic [31:0] tb_d = '0;

    always #4 clk = ~clk;

    tx_desc_ring_reader #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .halt_i(halt_i),
        .ring_base_i(ring_base_i), .busy_o(busy_o), .err_o(err_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
        .tx_last_o(tx_last_o), .tx_nocrc_o(tx_nocrc_o), .underrun_i(underrun_i)
    );

    always @(posedge clk) begin
        if (tb_we)
            mem[tb_a] <= tb_d;
        else if (mem_wr_o)
            mem[mem_addr_o[7:0]] <= mem_wdata_o;
        if (mem_rd_o)
            mem_rdata_i <= mem[mem_addr_o[7:0]];
        rdy_cnt <= rdy_cnt + 1;
        tx_ready_i <= (rdy_mode == 0) ? 1'b1 :
                      (rdy_mode == 1) ? (rdy_cnt[0] ^ rdy_cnt[2]) : 1'b0;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop and compare every accepted byte
    always @(negedge clk) begin
        if (!rst && tx_valid_o && tx_ready_i) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected byte", {22'd0, tx_nocrc_o, tx_last_o, tx_data_o}, 32'd0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check({tx_nocrc_o, tx_last_o, tx_data_o} == e, "R3/R4 byte",
                      {22'd0, tx_nocrc_o, tx_last_o, tx_data_o}, {22'd0, e});
            end
        end
    end

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = a[7:0]; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed + 7 * k);
    endfunction

    // driver: place descriptor and buffer, push expected bytes
    task automatic put_desc(input int idx, input int bufa, input logic [31:0] ctrl,
                            input int seed, input bit expect_bytes);
        int len;
        len = int'(ctrl[10:0]);
        for (int j = 0; j < (len + 3) / 4; j++)
            poke(bufa + j, {pat(seed, 4*j+3), pat(seed, 4*j+2), pat(seed, 4*j+1), pat(seed, 4*j)});
        poke(BASE + 2*idx, bufa);
        poke(BASE + 2*idx + 1, ctrl);
        if (expect_bytes)
            for (int k = 0; k < len; k++)
                exp_q.push_back({ctrl[16], ctrl[15] && (k == len - 1), pat(seed, k)});
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !err_o && !tx_valid_o, "R1 reset state",
              {29'd0, busy_o, err_o, tx_valid_o}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic desc_is(input int idx, input logic [31:0] exp, input string req);
        check(mem[BASE + 2*idx + 1] == exp, req, mem[BASE + 2*idx + 1], exp);
    endtask

    task automatic q_empty(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        do_reset();

        // two-buffer frame, then a used descriptor between frames
        rdy_mode = 1;
        put_desc(0, 64, 32'h0000_0005, 8'h11, 1);
        put_desc(1, 80, 32'h0000_8003, 8'h40, 1);
        put_desc(2, 96, 32'h8000_8001, 8'h00, 0);
        pulse_start();
        wait_idle();
        q_empty("R3 all bytes of frame seen");
        desc_is(0, 32'h8000_0005, "R5 writeback first buffer");
        desc_is(1, 32'h8000_8003, "R5 writeback last buffer");
        desc_is(2, 32'h8000_8001, "R6 used descriptor untouched");
        check(!busy_o, "R6 idle after used", busy_o, 0);

        // resume at D2, wrap after D3 back to base (D0 is used)
        poke(BASE + 5, 32'h0001_8004);
        exp_q.push_back(0);
        void'(exp_q.pop_back());
        put_desc(2, 96, 32'h0001_8004, 8'h23, 1);
        put_desc(3, 112, 32'h4000_8002, 8'h77, 1);
        pulse_start();
        wait_idle();
        q_empty("R6 resume at held descriptor");
        desc_is(3, 32'hC000_8002, "R7 wrap entry written back");
        put_desc(0, 128, 32'h0000_8001, 8'h5A, 1);
        pulse_start();
        wait_idle();
        q_empty("R7 next after wrap is base");
        desc_is(0, 32'h8000_8001, "R7 base descriptor consumed");

        // used descriptor in mid-frame: D1 not last, D2 used
        put_desc(1, 144, 32'h0000_0002, 8'h90, 1);
        pulse_start();
        wait_idle();
        q_empty("R8 bytes before exhaustion");
        desc_is(2, 32'h8801_8004, "R8 exhausted flag written");
        check(err_o, "R8 sticky error", err_o, 1);

        // underrun
        do_reset();
        rdy_mode = 2;
        put_desc(0, 160, 32'h0000_8008, 8'h31, 0);
        put_desc(1, 176, 32'h0000_8001, 8'h62, 0);
        put_desc(2, 192, 32'h8000_0000, 8'h00, 0);
        pulse_start();
        for (int i = 0; i < 100 && !tx_valid_o; i++) @(negedge clk);
        underrun_i = 1'b1;
        @(negedge clk);
        underrun_i = 1'b0;
        wait_idle();
        desc_is(0, 32'h9000_8008, "R9 underrun flag written");
        check(err_o, "R9 error set", err_o, 1);
        rdy_mode = 1;
        exp_q.push_back({1'b0, 1'b1, pat(8'h62, 0)});
        pulse_start();
        wait_idle();
        q_empty("R9 resume at following descriptor");
        desc_is(1, 32'h8000_8001, "R9 following descriptor consumed");

        // halt in mid-frame
        do_reset();
        put_desc(0, 192, 32'h0000_0002, 8'h0C, 1);
        put_desc(1, 200, 32'h0000_8002, 8'h1D, 1);
        put_desc(2, 208, 32'h0000_8001, 8'h2E, 0);
        put_desc(3, 216, 32'h8000_0000, 8'h00, 0);
        pulse_start();
        repeat (3) @(negedge clk);
        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        check(busy_o, "R10 busy holds through frame", busy_o, 1);
        wait_idle();
        q_empty("R10 frame completed after halt");
        desc_is(1, 32'h8000_8002, "R10 frame end written back");
        desc_is(2, 32'h0000_8001, "R10 next descriptor untouched");
        exp_q.push_back({1'b0, 1'b1, pat(8'h2E, 0)});
        pulse_start();
        wait_idle();
        q_empty("R10 restart after halt");
        desc_is(2, 32'h8000_8001, "R10 restart consumes next");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule